// File: doc/BRIEF.md
# Bridge Fault Supervisor with Short-Circuit Retry

This block sits between the digital fault indications of a full-bridge motor driver and the two control points that act on them. One is the bridge disable line that forces every output switch off. The other is the enable for the open-drain fault flag, which pulls the flag low. It does not contain the comparators, the temperature sensor or the charge pump. It consumes their already-synchronised results: a lead short detect, an undervoltage bit for each of the two internal supplies, and a die temperature code.

A lead short turns the bridge off for a fixed retry interval and then lets it try again. The flag stays asserted until a retry finds the short gone. The short detect is ignored during a blanking window at the start of every turn-on, so switching transients cannot trip it. Temperature has two levels. The lower level is a warning that only asserts the flag. The upper level is a shutdown with hysteresis. After power-up and after every wake from sleep, drive is held off for a settling interval. In sleep the flag is released and the retry sequence is cleared. Every interval is a cycle count derived from the clock rate, so a test setup can shrink it.

Top module: `mdrv_fault_supervisor`

## Requirements
- R1: Out of reset with no fault present, bridge_off_o is 1 and fault_pull_o is 0.
- R2: While awake_i is 0, bridge_off_o is 1 and fault_pull_o is 0, whatever the fault inputs are.
- R3: From the first clock edge at which awake_i is sampled 1 (after reset or after sleep), the bridge is held off for WAKE_CYC edges. The hold alone does not assert fault_pull_o.
- R4: uv_pump_i or uv_reg_i at 1 sets bridge_off_o and fault_pull_o in the same cycle (combinationally) while awake. Both clear when the undervoltage goes away, unless another cause holds them.
- R5: A short sampled while armed sets bridge_off_o and fault_pull_o from the next cycle. The bridge stays off for exactly RETRY_CYC cycles from the short alone.
- R6: short_det_i is sampled only once the bridge has been continuously enabled for DEAD_CYC cycles. A short seen earlier in a turn-on has no effect.
- R7: After the retry interval the bridge is re-enabled with the flag still asserted. If the short is present when blanking ends, R5 repeats. If it is absent, fault_pull_o is released on the next cycle.
- R8: temp_code_i >= WARN_CODE asserts fault_pull_o from the next cycle without disabling the bridge. Codes are unsigned, in degrees.
- R9: temp_code_i >= SHUT_CODE disables the bridge from the next cycle. It stays disabled until temp_code_i < SHUT_CODE - HYST_CODE is sampled.
- R10: Sleep clears the retry sequence, so after wake no holdoff or flag remains from a prior short.
- R11: In any mix of inputs, bridge_off_o is the OR of sleep, wake hold, undervoltage, thermal shutdown and short holdoff. While awake, fault_pull_o is the OR of undervoltage, warning, shutdown and a retry sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| awake_i | input | 1 | 1 = operating, 0 = sleep |
| short_det_i | input | 1 | Lead short to supply or ground detected |
| uv_pump_i | input | 1 | Charge pump supply undervoltage |
| uv_reg_i | input | 1 | Low-side regulator undervoltage |
| temp_code_i | input | TEMP_W | Die temperature code, degrees |
| bridge_off_o | output | 1 | 1 forces all bridge switches off |
| fault_pull_o | output | 1 | 1 pulls the open-drain fault flag low |

## Verification
A stuck retry state shows as a bridge that stays off, or a flag that never releases, one retry interval after a short clears. The bench model catches this within RETRY_CYC plus DEAD_CYC cycles. A wrong blanking count shows at the ports a single cycle early or late, as a trip on a transient short. A thermal state register that loses its hysteresis shows as the bridge re-enabling at codes between the release and shutdown levels. A wake counter error shows as the bridge enabling at the wrong edge after awake_i rises. Every output is compared against the model on every cycle, so each of these divergences is reported in the cycle it first appears.

// File: rtl/fsup_pkg.sv
package fsup_pkg;
  typedef enum logic [1:0] {
    RS_RUN   = 2'd0,
    RS_HOLD  = 2'd1,
    RS_RETRY = 2'd2
  } retry_st_e;

  function automatic int cyc_from_us(input int clk_khz, input int us);
    return (clk_khz * us) / 1000;
  endfunction
endpackage

// File: rtl/fsup_wake_hold.sv
module fsup_wake_hold #(
  parameter int HOLD_CYC = 200000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  output logic hold_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (!awake_i)     cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign hold_o = (cnt_q != LAST);

  assert_sleep_rearm_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_i |=> hold_o);
endmodule

// File: rtl/fsup_thermal.sv
module fsup_thermal #(
  parameter int TW        = 8,
  parameter int WARN_CODE = 160,
  parameter int SHUT_CODE = 175,
  parameter int HYST_CODE = 15
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [TW-1:0] temp_i,
  output logic          warn_o,
  output logic          shut_o
);
  localparam logic [TW-1:0] WARN_C = TW'(WARN_CODE);
  localparam logic [TW-1:0] SHUT_C = TW'(SHUT_CODE);
  localparam logic [TW-1:0] LOW_C  = TW'(SHUT_CODE - HYST_CODE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      warn_o <= 1'b0;
      shut_o <= 1'b0;
    end else begin
      warn_o <= (temp_i >= WARN_C);
      if (temp_i >= SHUT_C)     shut_o <= 1'b1;
      else if (temp_i < LOW_C)  shut_o <= 1'b0;
    end
  end

  assert_warn_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= WARN_C) |=> warn_o);
  assert_shut_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (temp_i >= SHUT_C) |=> shut_o);
  assert_shut_hyst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shut_o && temp_i >= LOW_C) |=> shut_o);
endmodule

// File: rtl/fsup_short_retry.sv
module fsup_short_retry
  import fsup_pkg::*;
#(
  parameter int DEAD_CYC  = 100,
  parameter int RETRY_CYC = 240000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic awake_i,
  input  logic bridge_off_i,
  input  logic short_i,
  output logic holdoff_o,
  output logic flag_o
);
  localparam int BW = $clog2(DEAD_CYC + 1);
  localparam int RW = $clog2(RETRY_CYC + 1);
  localparam logic [BW-1:0] DEAD_C = BW'(DEAD_CYC);
  localparam logic [RW-1:0] LAST_C = RW'(RETRY_CYC - 1);

  logic [BW-1:0] blank_q;
  logic [RW-1:0] tmr_q;
  retry_st_e     st_q;
  logic          armed;

  assign armed = (blank_q == DEAD_C);

  // blanking restarts on every turn-on of the bridge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           blank_q <= '0;
    else if (bridge_off_i) blank_q <= '0;
    else if (!armed)       blank_q <= blank_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= RS_RUN;
      tmr_q <= '0;
    end else if (!awake_i) begin
      st_q  <= RS_RUN;
      tmr_q <= '0;
    end else begin
      unique case (st_q)
        RS_RUN: if (armed && short_i) begin
          st_q  <= RS_HOLD;
          tmr_q <= '0;
        end
        RS_HOLD: if (tmr_q == LAST_C) st_q <= RS_RETRY;
                 else                 tmr_q <= tmr_q + 1'b1;
        RS_RETRY: if (armed) begin
          st_q  <= short_i ? RS_HOLD : RS_RUN;
          tmr_q <= '0;
        end
        default: st_q <= RS_RUN;
      endcase
    end
  end

  assign holdoff_o = (st_q == RS_HOLD);
  assign flag_o    = (st_q != RS_RUN);

  assert_trip_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_i && st_q == RS_RUN && armed && short_i) |=> holdoff_o);
  assert_blank_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_i && st_q == RS_RUN && !armed) |=> (st_q == RS_RUN));
  assert_retry_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_i && st_q == RS_RETRY && armed && !short_i) |=> !flag_o);
  assert_sleep_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_i |=> !flag_o);
endmodule

// File: rtl/mdrv_fault_supervisor.sv
module mdrv_fault_supervisor
  import fsup_pkg::*;
#(
  parameter int CLK_KHZ   = 200000,
  parameter int RETRY_US  = 1200,
  parameter int WAKE_US   = 1000,
  parameter int DEAD_CYC  = 100,
  parameter int TEMP_W    = 8,
  parameter int WARN_CODE = 160,
  parameter int SHUT_CODE = 175,
  parameter int HYST_CODE = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              awake_i,
  input  logic              short_det_i,
  input  logic              uv_pump_i,
  input  logic              uv_reg_i,
  input  logic [TEMP_W-1:0] temp_code_i,
  output logic              bridge_off_o,
  output logic              fault_pull_o
);
  localparam int RETRY_CYC = cyc_from_us(CLK_KHZ, RETRY_US);
  localparam int WAKE_CYC  = cyc_from_us(CLK_KHZ, WAKE_US);

  logic wake_hold, warn, shut, holdoff, retry_flag, uv_any;

  assign uv_any = uv_pump_i | uv_reg_i;

  fsup_wake_hold #(.HOLD_CYC(WAKE_CYC)) u_wake (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .awake_i(awake_i),
    .hold_o (wake_hold)
  );

  fsup_thermal #(
    .TW(TEMP_W), .WARN_CODE(WARN_CODE), .SHUT_CODE(SHUT_CODE), .HYST_CODE(HYST_CODE)
  ) u_therm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .temp_i(temp_code_i),
    .warn_o(warn),
    .shut_o(shut)
  );

  fsup_short_retry #(.DEAD_CYC(DEAD_CYC), .RETRY_CYC(RETRY_CYC)) u_retry (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .awake_i     (awake_i),
    .bridge_off_i(bridge_off_o),
    .short_i     (short_det_i),
    .holdoff_o   (holdoff),
    .flag_o      (retry_flag)
  );

  assign bridge_off_o = !awake_i | wake_hold | uv_any | shut | holdoff;
  assign fault_pull_o = awake_i & (uv_any | warn | shut | retry_flag);

  assert_sleep_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !awake_i |-> (bridge_off_o && !fault_pull_o));
  assert_uv_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (awake_i && uv_any) |-> (bridge_off_o && fault_pull_o));
endmodule

// File: tb/tb_mdrv_fault_supervisor.sv
module tb_mdrv_fault_supervisor;
  localparam int CLK_KHZ = 20;
  localparam int RETRY   = (CLK_KHZ * 1200) / 1000;
  localparam int WAKE    = (CLK_KHZ * 1000) / 1000;
  localparam int DEAD    = 3;
  localparam int WARN    = 160;
  localparam int SHUT    = 175;
  localparam int HYST    = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic awake = 1'b1, short_det = 1'b0, uv_p = 1'b0, uv_r = 1'b0;
  logic [7:0] temp = 8'd100;
  logic bridge_off, fault_pull;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";
  bit cmp_en = 1'b0;

  always #2.5 clk = ~clk;

  mdrv_fault_supervisor #(
    .CLK_KHZ(CLK_KHZ), .DEAD_CYC(DEAD), .TEMP_W(8),
    .WARN_CODE(WARN), .SHUT_CODE(SHUT), .HYST_CODE(HYST)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .awake_i(awake), .short_det_i(short_det),
    .uv_pump_i(uv_p), .uv_reg_i(uv_r), .temp_code_i(temp),
    .bridge_off_o(bridge_off), .fault_pull_o(fault_pull)
  );

  // reference model built from the requirements
  int m_wk, m_blank, m_st, m_cnt;
  bit m_warn, m_shut;

  function automatic bit exp_off();
    return !awake || (m_wk != WAKE) || uv_p || uv_r || m_shut || (m_st == 1);
  endfunction
  function automatic bit exp_flag();
    return awake && (uv_p || uv_r || m_warn || m_shut || (m_st != 0));
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wk <= 0; m_blank <= 0; m_st <= 0; m_cnt <= 0; m_warn <= 0; m_shut <= 0;
    end else begin
      m_wk <= !awake ? 0 : (m_wk != WAKE ? m_wk + 1 : m_wk);
      m_warn <= (temp >= WARN);
      if (temp >= SHUT) m_shut <= 1'b1;
      else if (temp < SHUT - HYST) m_shut <= 1'b0;
      m_blank <= exp_off() ? 0 : (m_blank != DEAD ? m_blank + 1 : m_blank);
      if (!awake) begin
        m_st <= 0; m_cnt <= 0;
      end else if (m_st == 0) begin
        if (m_blank == DEAD && short_det) begin m_st <= 1; m_cnt <= 0; end
      end else if (m_st == 1) begin
        if (m_cnt == RETRY - 1) m_st <= 2; else m_cnt <= m_cnt + 1;
      end else if (m_blank == DEAD) begin
        m_st <= short_det ? 1 : 0; m_cnt <= 0;
      end
    end
  end

  task automatic chk(string req, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0b expected=%0b at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      chk(cur_req, "bridge_off", bridge_off, exp_off());
      chk(cur_req, "fault_pull", fault_pull, exp_flag());
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int hold_len;
    void'($urandom(32'd2024));
    step(3);
    rst_n = 1'b1;
    #0;
    // R1: reset state
    chk("R1", "bridge_off reset", bridge_off, 1'b1);
    chk("R1", "fault_pull reset", fault_pull, 1'b0);
    cmp_en = 1'b1;
    // R3: power-up hold lasts WAKE edges, no flag
    cur_req = "R3";
    step(WAKE - 1);
    chk("R3", "still held", bridge_off, 1'b1);
    step(1);
    chk("R3", "released", bridge_off, 1'b0);
    chk("R3", "no flag", fault_pull, 1'b0);
    // R4: undervoltage on each supply
    cur_req = "R4";
    uv_p = 1'b1; #1;
    chk("R4", "uv pump off", bridge_off, 1'b1);
    step(2); uv_p = 1'b0; uv_r = 1'b1; step(2); uv_r = 1'b0; step(2);
    // R6: short inside blanking ignored
    cur_req = "R6";
    uv_r = 1'b1; step(1); uv_r = 1'b0; short_det = 1'b1; step(DEAD);
    short_det = 1'b0; step(2);
    chk("R6", "blank ignored", fault_pull, 1'b0);
    step(DEAD + 2);
    // R5/R7: persistent short gives repeated retries
    cur_req = "R5";
    short_det = 1'b1; step(1); short_det = 1'b1;
    hold_len = 0;
    while (bridge_off && hold_len < 10 * RETRY) begin step(1); hold_len++; end
    chk("R5", "holdoff length", logic'(hold_len == RETRY), 1'b1);
    cur_req = "R7";
    step(3 * RETRY);
    short_det = 1'b0;
    step(2 * RETRY);
    chk("R7", "flag released", fault_pull, 1'b0);
    chk("R7", "bridge on", bridge_off, 1'b0);
    // R8/R9: temperature ramp
    cur_req = "R8";
    temp = 8'd159; step(2); temp = 8'd160; step(2);
    chk("R8", "warn flag", fault_pull, 1'b1);
    chk("R8", "warn no off", bridge_off, 1'b0);
    cur_req = "R9";
    temp = 8'd175; step(2);
    chk("R9", "shutdown", bridge_off, 1'b1);
    temp = 8'd160; step(3);
    chk("R9", "hysteresis hold", bridge_off, 1'b1);
    temp = 8'd159; step(2);
    chk("R9", "shutdown released", bridge_off, 1'b0);
    temp = 8'd100; step(DEAD + 2);
    // R10: sleep during holdoff clears retry
    cur_req = "R10";
    short_det = 1'b1; step(2); short_det = 1'b0; step(3);
    awake = 1'b0; step(1);
    cur_req = "R2";
    uv_p = 1'b1; temp = 8'd190; short_det = 1'b1; step(2);
    chk("R2", "sleep flag released", fault_pull, 1'b0);
    chk("R2", "sleep off", bridge_off, 1'b1);
    uv_p = 1'b0; temp = 8'd100; short_det = 1'b0; step(2);
    cur_req = "R10";
    awake = 1'b1; step(WAKE + 1);
    chk("R10", "no stale flag", fault_pull, 1'b0);
    chk("R10", "no stale holdoff", bridge_off, 1'b0);
    // R11: random mix
    cur_req = "R11";
    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 400) == 0) awake = ~awake;
      if (($urandom % 8) == 0) short_det = (($urandom % 3) == 0);
      uv_p = (($urandom % 60) == 0);
      uv_r = (($urandom % 60) == 0);
      if (($urandom % 25) == 0) temp = 8'(150 + ($urandom % 35));
      step(1);
    end
    cmp_en = 1'b0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule